// File: doc/BRIEF.md
# Dual-Bank GPIO Register Controller

This block exposes a set of general-purpose pins to software through a small byte-wide register window that behaves like port I/O. The pins are divided into a core bank and a resume bank at a parameterised split index. Each bank has three register groups: enable, direction and level. The resume bank uses a copy of the core bank's layout placed 0x20 higher. Its pins are renumbered from zero, starting at the split index.

On the pin side the block gives a per-pin output enable, a per-pin output value, and a two-flop synchronizer for each input. The output value comes from a level latch. That latch only accepts writes while the pin is configured as an output. The level cannot be preloaded before the direction changes, so a pin that turns into an output first drives the latched value, which is 0 after reset.

Three configurations are intended: 14 pins split at 10, 14 pins split at 5, and 30 pins split at 21. The reset value of each bank's enable group is a parameter. Reads are combinational from the address, and writes take effect at the next rising clock edge.

Top module: `gpio_dualwell_ctrl`

## Requirements
- R1: Address map. Bit 5 of the address selects the bank (0 core, 1 resume). Bits 3:2 select the group: 00 enable, 01 direction, 10 level. Bits 1:0 select the byte. Byte k of a group holds bank pins 8k to 8k+7, and pin n sits at bit n mod 8. A write stores the written byte into the enable or direction group.
- R2: A global pin p at or above RESUME_SPLIT is pin p-RESUME_SPLIT of the resume bank. Pins below the split are core pin p.
- R3: After reset, the enable bits follow CORE_EN_RST and RES_EN_RST. With the defaults, core pins 0-6 and resume pins 0-2 are enabled and the others are disabled. All direction bits read 1, all level latches are 0, and no pin is driven.
- R4: A direction bit of 1 makes the pin an input and 0 makes it an output. pin_oe is 1 exactly when the pin is enabled and its direction bit is 0.
- R5: A write to a level bit is discarded while that pin's direction bit is 1. While the pin is an output, the written value appears on pin_out after the clock edge.
- R6: A pin that changes from input to output drives its current latch value at once. After reset that value is 0.
- R7: A disabled pin never asserts pin_oe, and its level bit reads 0.
- R8: For an enabled input pin, the level bit shows pin_in through two flops. A change made between edges appears after the second following rising edge.
- R9: For an enabled output pin, the level bit reads back the value being driven.
- R10: The following read as zero, and writes to them change no state: addresses with bit 4 or bits 7:6 set, group code 11, bytes beyond a bank's pin count, and bits above the last pin of a byte.
- R11: bus_rdata follows bus_addr in the same cycle. A write is applied at the rising edge where bus_wr is high.
- R12: With 30 pins split at 21, the core bank spans three bytes and the resume bank spans two bytes, and readback follows R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pin_out | output | NUM_PINS | Per-pin output value (level latch) |

## Verification
The assertions assume the following:
- Bus address, strobe and data settle between rising edges.
- pin_in may change at any time, since it is only seen through the synchronizer.
- Reset is held for at least one edge before any checked window starts.

The bench drives every bus signal and pin input on the falling edge, so the inputs are stable at each rising edge. It samples only after the combinational read path has settled. Write sequences use only the documented group codes, except where they deliberately target the unmapped holes of R10.

// File: rtl/gpio_dw_pkg.sv
package gpio_dw_pkg;
    typedef enum logic [1:0] {
        GRP_EN   = 2'd0,
        GRP_DIR  = 2'd1,
        GRP_LVL  = 2'd2,
        GRP_NONE = 2'd3
    } grp_e;

    localparam int BANK_MAX_PINS  = 32;
    localparam int BANK_MAX_BYTES = BANK_MAX_PINS / 8;
endpackage

// File: rtl/gpio_dw_decode.sv
module gpio_dw_decode
    import gpio_dw_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CORE_BYTES = 2,
    parameter int RES_BYTES  = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              bank_res,
    output grp_e              grp,
    output logic [1:0]        byte_sel
);
    localparam logic [2:0] CB = 3'(CORE_BYTES);
    localparam logic [2:0] RB = 3'(RES_BYTES);

    logic       upper_clear;
    logic [2:0] byte_lim;

    always_comb begin
        bank_res    = addr[5];
        byte_sel    = addr[1:0];
        grp         = grp_e'(addr[3:2]);
        upper_clear = (addr[ADDR_W-1:6] == '0) && !addr[4];
        byte_lim    = bank_res ? RB : CB;
        hit         = upper_clear && (grp != GRP_NONE) && ({1'b0, byte_sel} < byte_lim);
    end
endmodule

// File: rtl/gpio_dw_sync.sv
module gpio_dw_sync #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout = stage2_q;

    // Edges since reset, saturating at two, so the check never looks past reset.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            age_q <= 2'd0;
        else if (age_q != 2'd2)
            age_q <= age_q + 2'd1;
    end

    // R8: the output is the input as sampled two edges earlier
    p_sync_two_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpio_dw_bank.sv
module gpio_dw_bank
    import gpio_dw_pkg::*;
#(
    parameter int          N      = 8,
    parameter logic [31:0] EN_RST = 32'h0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  grp_e         grp,
    input  logic [1:0]   byte_sel,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    input  logic [N-1:0] sync_in,
    output logic [N-1:0] oe,
    output logic [N-1:0] dout
);
    logic [N-1:0] en_q;
    logic [N-1:0] dir_q;
    logic [N-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= EN_RST[N-1:0];
            dir_q <= '1;
            lat_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < N; i++) begin
                if (byte_sel == 2'(i / 8)) begin
                    unique case (grp)
                        GRP_EN:  en_q[i]  <= wdata[i % 8];
                        GRP_DIR: dir_q[i] <= wdata[i % 8];
                        GRP_LVL: if (!dir_q[i]) lat_q[i] <= wdata[i % 8];
                        default: ;
                    endcase
                end
            end
        end
    end

    assign oe   = en_q & ~dir_q;
    assign dout = lat_q;

    logic [BANK_MAX_PINS-1:0] en_pad;
    logic [BANK_MAX_PINS-1:0] dir_pad;
    logic [BANK_MAX_PINS-1:0] lvl_pad;

    always_comb begin
        en_pad  = '0;
        dir_pad = '0;
        lvl_pad = '0;
        en_pad[N-1:0]  = en_q;
        dir_pad[N-1:0] = dir_q;
        lvl_pad[N-1:0] = en_q & ((dir_q & sync_in) | (~dir_q & lat_q));
        unique case (grp)
            GRP_EN:  rdata = en_pad[{byte_sel, 3'b000} +: 8];
            GRP_DIR: rdata = dir_pad[{byte_sel, 3'b000} +: 8];
            GRP_LVL: rdata = lvl_pad[{byte_sel, 3'b000} +: 8];
            default: rdata = 8'h00;
        endcase
    end

    // R5: a level write never alters a latch whose pin was an input at that edge
    p_lvl_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && grp == GRP_LVL) |=> (((lat_q ^ $past(lat_q)) & $past(dir_q)) == '0));

    // R1: enable bits only move on an enable-group write
    p_en_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && grp == GRP_EN) |=> $stable(en_q));

    // R4: direction bits only move on a direction-group write
    p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && grp == GRP_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_dualwell_ctrl.sv
module gpio_dualwell_ctrl
    import gpio_dw_pkg::*;
#(
    parameter int          NUM_PINS     = 14,
    parameter int          RESUME_SPLIT = 10,
    parameter logic [31:0] CORE_EN_RST  = 32'h0000_007F,
    parameter logic [31:0] RES_EN_RST   = 32'h0000_0007
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out
);
    localparam int CORE_PINS  = RESUME_SPLIT;
    localparam int RES_PINS   = NUM_PINS - RESUME_SPLIT;
    localparam int CORE_BYTES = (CORE_PINS + 7) / 8;
    localparam int RES_BYTES  = (RES_PINS + 7) / 8;

    logic       hit;
    logic       bank_res;
    grp_e       grp;
    logic [1:0] byte_sel;

    gpio_dw_decode #(
        .ADDR_W     (8),
        .CORE_BYTES (CORE_BYTES),
        .RES_BYTES  (RES_BYTES)
    ) u_decode (
        .addr     (bus_addr),
        .hit      (hit),
        .bank_res (bank_res),
        .grp      (grp),
        .byte_sel (byte_sel)
    );

    logic [NUM_PINS-1:0] pin_sync;

    gpio_dw_sync #(.W(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_sync)
    );

    logic [7:0] core_rd;
    logic [7:0] res_rd;
    logic       core_wr;
    logic       res_wr;

    assign core_wr = bus_wr && hit && !bank_res;
    assign res_wr  = bus_wr && hit && bank_res;

    gpio_dw_bank #(.N(CORE_PINS), .EN_RST(CORE_EN_RST)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (core_wr),
        .grp      (grp),
        .byte_sel (byte_sel),
        .wdata    (bus_wdata),
        .rdata    (core_rd),
        .sync_in  (pin_sync[CORE_PINS-1:0]),
        .oe       (pin_oe[CORE_PINS-1:0]),
        .dout     (pin_out[CORE_PINS-1:0])
    );

    gpio_dw_bank #(.N(RES_PINS), .EN_RST(RES_EN_RST)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (res_wr),
        .grp      (grp),
        .byte_sel (byte_sel),
        .wdata    (bus_wdata),
        .rdata    (res_rd),
        .sync_in  (pin_sync[NUM_PINS-1:CORE_PINS]),
        .oe       (pin_oe[NUM_PINS-1:CORE_PINS]),
        .dout     (pin_out[NUM_PINS-1:CORE_PINS])
    );

    always_comb begin
        if (!hit)
            bus_rdata = 8'h00;
        else if (bank_res)
            bus_rdata = res_rd;
        else
            bus_rdata = core_rd;
    end

    // R10: a write to an unmapped address leaves every pin output untouched
    p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit) |=> ($stable(pin_oe) && $stable(pin_out)));
endmodule

// File: tb/tb_gpio_dualwell_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_dualwell_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [13:0] pin_in = '0;
    logic [13:0] pin_oe;
    logic [13:0] pin_out;
    logic [7:0]  rdata2;
    logic [29:0] pin_in2 = '0;
    logic [29:0] pin_oe2;
    logic [29:0] pin_out2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_dualwell_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    gpio_dualwell_ctrl #(
        .NUM_PINS(30), .RESUME_SPLIT(21),
        .CORE_EN_RST(32'h001F_FFFF), .RES_EN_RST(32'h0000_01FF)
    ) dut_wide (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata2),
        .pin_in(pin_in2), .pin_oe(pin_oe2), .pin_out(pin_out2)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, {24'd0, d}, {24'd0, exp});
    endtask

    task automatic t_reset;
        rd_chk("R3 core enable byte0", 8'h00, 8'h7F);
        rd_chk("R3 core enable byte1", 8'h01, 8'h00);
        rd_chk("R3 resume enable", 8'h20, 8'h07);
        rd_chk("R3 core dir byte0", 8'h04, 8'hFF);
        rd_chk("R10 core dir byte1 spare bits", 8'h05, 8'h03);
        rd_chk("R3 resume dir", 8'h24, 8'h0F);
        chk("R3 no pin driven", {18'd0, pin_oe}, 32'd0);
        chk("R3 latches zero", {18'd0, pin_out}, 32'd0);
        @(negedge clk); bus_addr = 8'h06; #1;
        chk("R12 wide core dir byte2", {24'd0, rdata2}, 32'h1F);
        @(negedge clk); bus_addr = 8'h25; #1;
        chk("R12 wide resume dir byte1", {24'd0, rdata2}, 32'h01);
        @(negedge clk); bus_addr = 8'h21; #1;
        chk("R12 wide resume enable byte1", {24'd0, rdata2}, 32'h01);
    endtask

    task automatic t_disabled;
        wr(8'h05, 8'h00);
        chk("R7 disabled output not driven", {30'd0, pin_oe[9:8]}, 32'd0);
        @(negedge clk); pin_in[8] = 1'b1;
        repeat (3) @(negedge clk);
        rd_chk("R7 disabled level reads zero", 8'h09, 8'h00);
        wr(8'h01, 8'h03);
        rd_chk("R1 enable write readback", 8'h01, 8'h03);
        chk("R4 enabled output drives", {30'd0, pin_oe[9:8]}, 32'd3);
        rd_chk("R9 output reads latch", 8'h09, 8'h00);
    endtask

    task automatic t_enable;
        wr(8'h20, 8'h0F);
        rd_chk("R1 resume enable write", 8'h20, 8'h0F);
        chk("R4 inputs not driven", {18'd0, pin_oe}, 32'h0300);
    endtask

    task automatic t_discard;
        wr(8'h08, 8'h04);
        chk("R5 level write discarded on input", {31'd0, pin_out[2]}, 32'd0);
        rd_chk("R5 level readback unchanged", 8'h08, 8'h00);
        wr(8'h04, 8'hFB);
        chk("R4 pin2 now output", {18'd0, pin_oe}, 32'h0304);
        chk("R6 drives reset latch value", {31'd0, pin_out[2]}, 32'd0);
        wr(8'h08, 8'h04);
        chk("R5 level write applied on output", {31'd0, pin_out[2]}, 32'd1);
        rd_chk("R9 driven level reads back", 8'h08, 8'h04);
    endtask

    task automatic t_sync;
        @(negedge clk);
        pin_in[0] = 1'b1; bus_addr = 8'h08; bus_wr = 1'b0;
        @(negedge clk); #1;
        chk("R8 not visible after one edge", {24'd0, bus_rdata}, 32'h04);
        @(negedge clk); #1;
        chk("R8 visible after two edges", {24'd0, bus_rdata}, 32'h05);
    endtask

    task automatic t_resume;
        wr(8'h24, 8'h07);
        chk("R2 resume pin3 is global 13", {18'd0, pin_oe}, 32'h2304);
        wr(8'h28, 8'h08);
        chk("R2 resume level drives pin13", {31'd0, pin_out[13]}, 32'd1);
        @(negedge clk); pin_in[10] = 1'b1;
        repeat (3) @(negedge clk);
        rd_chk("R2 resume level readback", 8'h28, 8'h09);
        rd_chk("R1 core byte1 unaffected", 8'h09, 8'h00);
    endtask

    task automatic t_unmapped;
        logic [13:0] oe_s;
        logic [13:0] out_s;
        rd_chk("R10 group code 11", 8'h0C, 8'h00);
        rd_chk("R10 core byte past range", 8'h02, 8'h00);
        rd_chk("R10 resume byte past range", 8'h21, 8'h00);
        rd_chk("R10 high address bits", 8'h40, 8'h00);
        rd_chk("R10 address bit4", 8'h10, 8'h00);
        oe_s = pin_oe; out_s = pin_out;
        wr(8'h0C, 8'h00);
        wr(8'h2C, 8'hFF);
        wr(8'h21, 8'hFF);
        wr(8'h44, 8'hFF);
        wr(8'h14, 8'hFF);
        wr(8'h06, 8'h00);
        chk("R10 unmapped writes keep oe", {18'd0, pin_oe}, {18'd0, oe_s});
        chk("R10 unmapped writes keep out", {18'd0, pin_out}, {18'd0, out_s});
        rd_chk("R10 core dir intact", 8'h04, 8'hFB);
    endtask

    task automatic t_timing;
        @(negedge clk);
        bus_addr = 8'h04; bus_wdata = 8'hFF; bus_wr = 1'b1;
        #1;
        chk("R11 write not applied before edge", {24'd0, bus_rdata}, 32'hFB);
        chk("R11 oe before edge", {31'd0, pin_oe[2]}, 32'd1);
        @(negedge clk);
        bus_wr = 1'b0; #1;
        chk("R11 write applied at edge", {24'd0, bus_rdata}, 32'hFF);
        chk("R11 oe dropped at edge", {31'd0, pin_oe[2]}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_enable();
        t_discard();
        t_sync();
        t_resume();
        t_unmapped();
        t_timing();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule